// File: doc/BRIEF.md
# Belief-Propagation Message Update Element

This block performs one message-passing update for a single node of a stereo-matching grid. It uses a linear smoothness penalty over a disparity range of `L` labels. For each of the four neighbour directions it forms an aggregate from the node's data cost and the three incoming messages that do not come from that neighbour. It then runs a forward and a backward minimum pass with a programmable slope and stores the result as the new outgoing message.

The element holds no per-label message storage of its own. Message memory sits outside, in four banks of a two-port register file, one bank per direction, plus a data-cost bank. All banks share one read address and one write address. Each message bank keeps `L` label words at addresses `0..L-1`. The word at address `L` holds that message's normalization term. The update subtracts the stored term from each incoming word as it aggregates, instead of normalizing at write time. Forward-pass results are written over the old message words as soon as those words have been consumed. The backward pass reads them back and overwrites them with the final values. The new normalization terms are written last. A pulse on `start` begins an update and `done` pulses in the cycle of the last write.

Top module: `bp_msg_pe`

## Requirements
- R1: While reset is active and after its release, `done` and `wr_en` are low until a `start` is accepted.
- R2: While idle, `rd_addr` equals `L` (the normalization slot). During the `L` cycles that follow the accepting edge, it steps through `0..L-1` in ascending order.
- R3: For direction j and label d, the aggregate is `cost[d]` plus, for each k other than j, `msg_k[d] - norm_k` floored at zero. Here `norm_k` is the word at address `L` of bank k, and the sum is clamped to 65535. When the slope is 65535, every forward value equals this aggregate.
- R4: The forward value is `f[0] = h[0]` and `f[d] = min(h[d], f[d-1] + slope)`. It is written to address d of each bank, in ascending order of d. Bank j occupies bits `[16j+15:16j]` of `wr_msg`.
- R5: The backward pass reads the forward values in descending address order. It writes `b[L-1] = f[L-1]` and `b[d] = min(f[d], b[d+1] + slope)` back to address d.
- R6: Every addition saturates at 65535 instead of wrapping.
- R7: After the backward pass, a single write to address `L` stores, for each bank, the minimum of that bank's backward values as its new normalization term.
- R8: `done` is high for exactly one cycle, `2L+4` clock edges after the edge that accepted `start` (68 for `L=32`). A `start` seen while an update is running has no effect.
- R9: Each update issues exactly `2L+1` writes (L forward, L backward, one normalization), and no write occurs while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an update when idle |
| slope | input | 16 | Linear smoothness penalty per label step, held constant during an update |
| done | output | 1 | One-cycle pulse with the final write |
| rd_addr | output | $clog2(L+1) | Shared read address for all banks |
| rd_cost | input | 16 | Data-cost word, valid the cycle after its address |
| rd_msg | input | 16*NDIR | Message words of all banks, valid the cycle after the address |
| wr_en | output | 1 | Write strobe for all message banks |
| wr_addr | output | $clog2(L+1) | Shared write address |
| wr_msg | output | 16*NDIR | Write data, bank j at bits [16j+15:16j] |

## Verification
The embedded properties check these rules on every cycle:
- Consecutive forward values of a bank never rise by more than the slope, and the same holds for consecutive backward values.
- Backward write addresses step down by one.
- Forward read addresses step up by one.
- The stored normalization term never exceeds the last backward value.
- Writes happen only during an update, and `done` never lasts two cycles.

Only the scenarios can show the exact aggregate values: the floor at zero when a normalization term exceeds its message, saturation with large costs, and the precise completion latency. They also show that a second update chained on the first correctly consumes the normalization terms it left behind, and that a mid-update `start` leaves no trace.

// File: rtl/bp_pe_pkg.sv
package bp_pe_pkg;

    parameter int DW = 16;

    typedef logic [DW-1:0] word_t;

    localparam word_t WMAX = '1;

    function automatic word_t sat_add(input word_t a, input word_t b);
        logic [DW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[DW] ? WMAX : s[DW-1:0];
    endfunction

    function automatic word_t floor_sub(input word_t a, input word_t b);
        return (a > b) ? (a - b) : '0;
    endfunction

    function automatic word_t min2(input word_t a, input word_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/bp_pe_aggregate.sv
module bp_pe_aggregate
    import bp_pe_pkg::*;
#(
    parameter int NDIR = 4
) (
    input  word_t [NDIR-1:0] msg,
    input  word_t [NDIR-1:0] norm,
    input  word_t            cost,
    output word_t [NDIR-1:0] agg
);

    localparam int SW = DW + $clog2(NDIR + 1);

    word_t [NDIR-1:0] normed;
    logic  [SW-1:0]   total;
    logic  [SW-1:0]   part [NDIR];

    always_comb begin
        total = SW'(cost);
        for (int k = 0; k < NDIR; k++) begin
            normed[k] = floor_sub(msg[k], norm[k]);
            total     = total + SW'(normed[k]);
        end
        for (int j = 0; j < NDIR; j++) begin
            part[j] = total - SW'(normed[j]);
            agg[j]  = (part[j] > SW'(WMAX)) ? WMAX : part[j][DW-1:0];
        end
    end

endmodule

// File: rtl/bp_pe_minpass.sv
module bp_pe_minpass
    import bp_pe_pkg::*;
(
    input  logic  use_fwd,
    input  logic  first,
    input  word_t fwd_in,
    input  word_t bwd_in,
    input  word_t prev,
    input  word_t slope,
    output word_t y
);

    word_t cand;
    word_t carried;

    always_comb begin
        cand    = use_fwd ? fwd_in : bwd_in;
        carried = sat_add(prev, slope);
        y       = first ? cand : min2(cand, carried);
    end

endmodule

// File: rtl/bp_pe_ctrl.sv
module bp_pe_ctrl #(
    parameter  int L  = 32,
    localparam int AW = $clog2(L + 1),
    localparam int CW = $clog2(2 * L + 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          cap_norm,
    output logic          agg_load,
    output logic          fwd_wr,
    output logic          fwd_first,
    output logic          bwd_wr,
    output logic          bwd_first,
    output logic          norm_wr,
    output logic          busy,
    output logic          done
);

    typedef enum logic {S_IDLE, S_RUN} st_e;

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cyc;
    } ctrl_t;

    localparam int LAST = 2 * L + 3;

    ctrl_t ctl_d, ctl_q;
    int    c;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.st  = S_RUN;
                    ctl_d.cyc = '0;
                end
            end
            default: begin
                if (int'(ctl_q.cyc) == LAST) begin
                    ctl_d.st  = S_IDLE;
                    ctl_d.cyc = '0;
                end else begin
                    ctl_d.cyc = ctl_q.cyc + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, cyc: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        c         = int'(ctl_q.cyc);
        busy      = (ctl_q.st == S_RUN);
        cap_norm  = busy && (c == 0);
        agg_load  = busy && (c >= 1) && (c <= L);
        fwd_wr    = busy && (c >= 2) && (c <= L + 1);
        fwd_first = busy && (c == 2);
        bwd_wr    = busy && (c >= L + 3) && (c <= 2 * L + 2);
        bwd_first = busy && (c == L + 3);
        norm_wr   = busy && (c == LAST);
        done      = norm_wr;

        if (busy && (c < L)) begin
            rd_addr = AW'(c);
        end else if (busy && (c >= L + 2) && (c <= 2 * L + 1)) begin
            rd_addr = AW'(2 * L + 1 - c);
        end else begin
            rd_addr = AW'(L);
        end

        if (fwd_wr) begin
            wr_addr = AW'(c - 2);
        end else if (bwd_wr) begin
            wr_addr = AW'(2 * L + 2 - c);
        end else begin
            wr_addr = AW'(L);
        end
    end

    // R2: forward read sweep climbs one label per cycle
    a_r2_fwd_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (c >= 1) && (c <= L - 1)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

    // R8: completion pulse lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/bp_msg_pe.sv
module bp_msg_pe
    import bp_pe_pkg::*;
#(
    parameter  int L    = 32,
    parameter  int NDIR = 4,
    localparam int AW   = $clog2(L + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DW-1:0]      slope,
    output logic               done,
    output logic [AW-1:0]      rd_addr,
    input  logic [DW-1:0]      rd_cost,
    input  logic [NDIR*DW-1:0] rd_msg,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [NDIR*DW-1:0] wr_msg
);

    typedef struct packed {
        word_t [NDIR-1:0] norm;
        word_t [NDIR-1:0] agg;
        word_t [NDIR-1:0] prev;
        word_t [NDIR-1:0] mn;
    } dp_t;

    dp_t dp_d, dp_q;

    logic cap_norm, agg_load, fwd_wr, fwd_first, bwd_wr, bwd_first, norm_wr, busy;

    word_t [NDIR-1:0] msg_in;
    word_t [NDIR-1:0] agg_w;
    word_t [NDIR-1:0] pass_w;

    assign msg_in = rd_msg;

    bp_pe_ctrl #(.L(L)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_addr   (rd_addr),
        .wr_addr   (wr_addr),
        .cap_norm  (cap_norm),
        .agg_load  (agg_load),
        .fwd_wr    (fwd_wr),
        .fwd_first (fwd_first),
        .bwd_wr    (bwd_wr),
        .bwd_first (bwd_first),
        .norm_wr   (norm_wr),
        .busy      (busy),
        .done      (done)
    );

    bp_pe_aggregate #(.NDIR(NDIR)) u_agg (
        .msg  (msg_in),
        .norm (dp_q.norm),
        .cost (rd_cost),
        .agg  (agg_w)
    );

    for (genvar j = 0; j < NDIR; j++) begin : g_pass
        bp_pe_minpass u_pass (
            .use_fwd (fwd_wr),
            .first   (fwd_wr ? fwd_first : bwd_first),
            .fwd_in  (dp_q.agg[j]),
            .bwd_in  (msg_in[j]),
            .prev    (dp_q.prev[j]),
            .slope   (slope),
            .y       (pass_w[j])
        );
    end

    always_comb begin
        dp_d = dp_q;
        if (cap_norm) begin
            dp_d.norm = msg_in;
        end
        if (agg_load) begin
            dp_d.agg = agg_w;
        end
        if (fwd_wr || bwd_wr) begin
            dp_d.prev = pass_w;
        end
        if (bwd_wr) begin
            for (int j = 0; j < NDIR; j++) begin
                dp_d.mn[j] = bwd_first ? pass_w[j] : min2(dp_q.mn[j], pass_w[j]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign wr_en  = fwd_wr || bwd_wr || norm_wr;
    assign wr_msg = norm_wr ? dp_q.mn : pass_w;

    // R9: storage is only written while an update is running
    a_r9_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R5: backward write addresses fall one per cycle
    a_r5_bwd_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (bwd_wr && !bwd_first) |-> (wr_addr == AW'($past(wr_addr) - 1'b1)));

    for (genvar j = 0; j < NDIR; j++) begin : g_chk
        // R4: a forward value never exceeds its predecessor plus the slope
        a_r4_fwd_slope: assert property (@(posedge clk) disable iff (!rst_n)
            (fwd_wr && !fwd_first) |->
            ({1'b0, wr_msg[j*DW +: DW]} <= ({1'b0, $past(wr_msg[j*DW +: DW])} + {1'b0, slope})));

        // R5: a backward value never exceeds its successor plus the slope
        a_r5_bwd_slope: assert property (@(posedge clk) disable iff (!rst_n)
            (bwd_wr && !bwd_first) |->
            ({1'b0, wr_msg[j*DW +: DW]} <= ({1'b0, $past(wr_msg[j*DW +: DW])} + {1'b0, slope})));

        // R7: stored term is no larger than the last backward value
        a_r7_norm_le_last: assert property (@(posedge clk) disable iff (!rst_n)
            norm_wr |-> (wr_msg[j*DW +: DW] <= $past(wr_msg[j*DW +: DW])));
    end

endmodule

// File: tb/bp_msg_pe_tb_top.sv
`timescale 1ns/1ps
module bp_msg_pe_tb_top;
    import bp_pe_pkg::*;

    localparam int L    = 32;
    localparam int NDIR = 4;
    localparam int AW   = $clog2(L + 1);

    typedef struct packed {
        logic [7:0]         tag;
        logic [AW-1:0]      addr;
        logic [NDIR*DW-1:0] data;
    } item_t;

    logic               clk;
    logic               rst_n;
    logic               start;
    logic [DW-1:0]      slope;
    logic               done;
    logic [AW-1:0]      rd_addr;
    logic [DW-1:0]      rd_cost;
    logic [NDIR*DW-1:0] rd_msg;
    logic               wr_en;
    logic [AW-1:0]      wr_addr;
    logic [NDIR*DW-1:0] wr_msg;

    logic [DW-1:0] cost_mem [L];
    logic [DW-1:0] msg_mem  [NDIR][L+1];

    item_t exp_q [$];
    int    n_tests, n_fail, n_writes, n_done;

    bp_msg_pe #(.L(L), .NDIR(NDIR)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .slope   (slope),
        .done    (done),
        .rd_addr (rd_addr),
        .rd_cost (rd_cost),
        .rd_msg  (rd_msg),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_msg  (wr_msg)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // two-port register file model: registered read, write on the edge
    always @(posedge clk) begin
        rd_cost <= (int'(rd_addr) < L) ? cost_mem[rd_addr] : '0;
        for (int k = 0; k < NDIR; k++) begin
            rd_msg[k*DW +: DW] <= msg_mem[k][rd_addr];
        end
        if (wr_en) begin
            for (int k = 0; k < NDIR; k++) begin
                msg_mem[k][wr_addr] <= wr_msg[k*DW +: DW];
            end
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    function automatic int sadd(input int a, input int b);
        return (a + b > 65535) ? 65535 : a + b;
    endfunction

    function automatic int fsub(input int a, input int b);
        return (a > b) ? a - b : 0;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) n_done++;
            if (wr_en) begin
                n_writes++;
                if (exp_q.size() == 0) begin
                    check("R9 unexpected write", 1, 0);
                end else begin
                    item_t it;
                    string nm;
                    it = exp_q.pop_front();
                    case (it.tag)
                        8'd3:    nm = "R3 aggregate";
                        8'd4:    nm = "R4 forward value";
                        8'd5:    nm = "R5 backward value";
                        8'd6:    nm = "R6 saturation";
                        default: nm = "R7 norm term";
                    endcase
                    check(nm, {wr_addr, wr_msg}, {it.addr, it.data});
                end
            end
        end
    end

    // driver: computes the expected write stream from the stored words
    task automatic push_expect(input int ftag);
        int nm [NDIR];
        int h  [NDIR][L];
        int f  [NDIR][L];
        int b  [NDIR][L];
        int mn [NDIR];
        item_t it;
        for (int k = 0; k < NDIR; k++) nm[k] = int'(msg_mem[k][L]);
        for (int d = 0; d < L; d++) begin
            int tot;
            tot = int'(cost_mem[d]);
            for (int k = 0; k < NDIR; k++) tot += fsub(int'(msg_mem[k][d]), nm[k]);
            for (int j = 0; j < NDIR; j++) begin
                int p;
                p = tot - fsub(int'(msg_mem[j][d]), nm[j]);
                h[j][d] = (p > 65535) ? 65535 : p;
            end
        end
        for (int d = 0; d < L; d++) begin
            it.tag  = 8'(ftag);
            it.addr = AW'(d);
            for (int j = 0; j < NDIR; j++) begin
                if (d == 0) f[j][d] = h[j][d];
                else        f[j][d] = (h[j][d] < sadd(f[j][d-1], int'(slope))) ? h[j][d] : sadd(f[j][d-1], int'(slope));
                it.data[j*DW +: DW] = DW'(f[j][d]);
            end
            exp_q.push_back(it);
        end
        for (int d = L - 1; d >= 0; d--) begin
            it.tag  = 8'd5;
            it.addr = AW'(d);
            for (int j = 0; j < NDIR; j++) begin
                if (d == L - 1) b[j][d] = f[j][d];
                else            b[j][d] = (f[j][d] < sadd(b[j][d+1], int'(slope))) ? f[j][d] : sadd(b[j][d+1], int'(slope));
                mn[j] = (d == L - 1 || b[j][d] < mn[j]) ? b[j][d] : mn[j];
                it.data[j*DW +: DW] = DW'(b[j][d]);
            end
            exp_q.push_back(it);
        end
        it.tag  = 8'd7;
        it.addr = AW'(L);
        for (int j = 0; j < NDIR; j++) it.data[j*DW +: DW] = DW'(mn[j]);
        exp_q.push_back(it);
    endtask

    task automatic run_node(input int ftag, input bit extra_start);
        int cnt;
        push_expect(ftag);
        n_writes = 0;
        n_done   = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 4 * L) begin
            start = extra_start && (cnt == 10);
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        check("R8 done latency", cnt, 2 * L + 4);
        repeat (extra_start ? 2 * L + 8 : 4) @(negedge clk);
        check("R8 single done", n_done, 1);
        check("R9 write count", n_writes, 2 * L + 1);
        check("R9 queue drained", exp_q.size(), 0);
        check("R2 idle read slot", rd_addr, L);
        exp_q.delete();
    endtask

    task automatic fill(input int seed, input int base, input int span, input int nbase);
        for (int d = 0; d < L; d++) begin
            cost_mem[d] = DW'(base + (d * 7 + seed * 3) % span);
            for (int k = 0; k < NDIR; k++) begin
                msg_mem[k][d] = DW'(base + (d * (k + 3) + seed * 11 + k * 5) % span);
            end
        end
        for (int k = 0; k < NDIR; k++) msg_mem[k][L] = DW'(nbase + k);
    endtask

    initial begin
        n_tests = 0;
        n_fail  = 0;
        rst_n   = 1'b0;
        start   = 1'b0;
        slope   = 16'd3;
        fill(1, 100, 200, 50);
        repeat (4) @(negedge clk);
        check("R1 done in reset", done, 0);
        check("R1 no write in reset", wr_en, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 done after reset", done, 0);
        check("R1 no write after reset", wr_en, 0);
        check("R2 idle read slot", rd_addr, L);

        // typical update, with a start pulse during the run (R8)
        run_node(4, 1'b1);

        // chained update reusing the stored terms (R4, R7)
        slope = 16'd5;
        run_node(4, 1'b0);

        // very large slope: forward equals aggregate (R3)
        fill(2, 0, 1000, 20);
        slope = 16'hFFFF;
        run_node(3, 1'b0);

        // saturation of sums and of prev + slope (R6)
        for (int d = 0; d < L; d++) begin
            cost_mem[d] = (d % 2 == 0) ? 16'hFFF0 : 16'h1234;
            for (int k = 0; k < NDIR; k++) msg_mem[k][d] = DW'(16'h9000 + d);
        end
        for (int k = 0; k < NDIR; k++) msg_mem[k][L] = '0;
        slope = 16'd1;
        run_node(6, 1'b0);

        // terms above every message: each floors at zero (R3)
        fill(3, 10, 50, 500);
        slope = 16'd2;
        run_node(3, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule